// File: doc/BRIEF.md
# Two-Write Four-Read XOR-Encoded Register File

This block is a small register file that accepts two independent writes and serves four independent reads in every clock cycle. It is built only from storage copies that each have a single write port and a combinational read port. Write port A owns one set of copies and write port B owns the other. Neither set holds plain data. The value of a register is the XOR of the entries at its address in set A and in set B.

When port A writes value X to address N, it reads set B at N through a copy kept for that purpose. It stores X XOR B[N] into every copy of set A. Port B does the same with the two sets swapped. Each final read port XORs one copy of set A with one copy of set B at its own address. With four readers, each set holds five copies: one serves the other writer's encoding read and four serve the final reads.

The block has no stream interface. Writes are accepted every cycle and there is no back-pressure. Reads are combinational, so every pin is a plain control or data pin. The user must keep the two writers off the same address in the same cycle.

Top module: `dual_write_xor_regfile`

## Requirements
- R1: While the reset input is low at a rising clock edge, every copy is cleared. After that edge, every address reads 0 on all four read ports.
- R2: Reads are combinational. A read port's data reflects a new read address in the same cycle, with no clock edge needed.
- R3: A write on port A (enable high at a rising edge) is returned by every read port addressing that location from just after that edge.
- R4: A write on port B (enable high at a rising edge) is returned by every read port addressing that location from just after that edge.
- R5: Writes on A and B in the same cycle to different addresses are both retained and read back correctly.
- R6: A location last written by one port and then overwritten by the other port returns the newest value.
- R7: A read of an address that is being written in the current cycle returns the old value until the clock edge.
- R8: A write port whose enable is low changes no stored value, whatever its address and data inputs carry.
- R9: Both write enables high with equal addresses is illegal. The bound checker flags it.
- R10: The four read ports use independent addresses. Read port k occupies bits [k*WIDTH +: WIDTH] of the read data bus and takes its address from bits [k*AW +: AW] of the read address bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear of all copies |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | AW (4) | Write port A address |
| wa_data | input | WIDTH (32) | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | AW (4) | Write port B address |
| wb_data | input | WIDTH (32) | Write port B data |
| rd_addr | input | NUM_RD*AW (16) | Packed read addresses, port k at [k*AW +: AW] |
| rd_data | output | NUM_RD*WIDTH (128) | Packed read data, port k at [k*WIDTH +: WIDTH] |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two writes. The bench issues A and B writes in one cycle to distinct addresses, including pairs that overwrite each other's earlier locations, and then reads all sixteen registers through the four ports against a model in the bench. The second pair is a write and a read of the same address. The bench holds a read port on the target address, samples it before the clock edge and expects the old value, then samples it after the edge and expects the new one.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

  // Selects which write port owns a memory set.
  typedef enum logic {
    OWNER_A = 1'b0,
    OWNER_B = 1'b1
  } xrf_owner_e;

  // One copy per final reader plus one copy that serves the peer writer's encoding read.
  function automatic int copies_per_set(input int num_rd);
    return num_rd + 1;
  endfunction

  // Index of the copy reserved for the peer writer.
  localparam int PEER_COPY = 0;

endpackage

// File: rtl/xrf_copy.sv
module xrf_copy #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        store[i] <= '0;
      end
    end else if (we) begin
      store[waddr] <= wdata;
    end
  end

  // Combinational read
  assign rdata = store[raddr];

endmodule

// File: rtl/xrf_set.sv
module xrf_set #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int NCOPY = 5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [WIDTH-1:0]       wdata,
  input  logic [NCOPY*AW-1:0]    raddr,
  output logic [NCOPY*WIDTH-1:0] rdata
);

  // All copies share the write side; every copy has its own read address.
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    xrf_copy #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH)
    ) u_copy (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr[c*AW +: AW]),
      .rdata (rdata[c*WIDTH +: WIDTH])
    );
  end

endmodule

// File: rtl/xrf_wr_encode.sv
module xrf_wr_encode #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] new_data,
  input  logic [WIDTH-1:0] peer_word,
  output logic [WIDTH-1:0] coded
);

  // Stored word is chosen so that coded ^ peer_word == new_data.
  assign coded = new_data ^ peer_word;

endmodule

// File: rtl/dual_write_xor_regfile.sv
module dual_write_xor_regfile
  import xrf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  parameter int NUM_RD = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wa_en,
  input  logic [AW-1:0]           wa_addr,
  input  logic [WIDTH-1:0]        wa_data,
  input  logic                    wb_en,
  input  logic [AW-1:0]           wb_addr,
  input  logic [WIDTH-1:0]        wb_data,
  input  logic [NUM_RD*AW-1:0]    rd_addr,
  output logic [NUM_RD*WIDTH-1:0] rd_data
);

  localparam int NCOPY = copies_per_set(NUM_RD);

  logic [NCOPY*AW-1:0]    set_raddr [2];
  logic [NCOPY*WIDTH-1:0] set_rdata [2];
  logic [WIDTH-1:0]       set_wdata [2];
  logic                   set_we    [2];
  logic [AW-1:0]          set_waddr [2];
  logic [WIDTH-1:0]       raw_data  [2];

  assign set_we[OWNER_A]    = wa_en;
  assign set_we[OWNER_B]    = wb_en;
  assign set_waddr[OWNER_A] = wa_addr;
  assign set_waddr[OWNER_B] = wb_addr;
  assign raw_data[OWNER_A]  = wa_data;
  assign raw_data[OWNER_B]  = wb_data;

  for (genvar s = 0; s < 2; s++) begin : g_set
    localparam int PEER = 1 - s;

    // The peer copy of this set is addressed by the other writer.
    assign set_raddr[s][PEER_COPY*AW +: AW] = set_waddr[PEER];
    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd_addr
      assign set_raddr[s][(k+1)*AW +: AW] = rd_addr[k*AW +: AW];
    end

    // Encode against the other set's pre-edge contents at the target address.
    xrf_wr_encode #(
      .WIDTH (WIDTH)
    ) u_enc (
      .new_data  (raw_data[s]),
      .peer_word (set_rdata[PEER][PEER_COPY*WIDTH +: WIDTH]),
      .coded     (set_wdata[s])
    );

    xrf_set #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .NCOPY (NCOPY)
    ) u_set (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (set_we[s]),
      .waddr (set_waddr[s]),
      .wdata (set_wdata[s]),
      .raddr (set_raddr[s]),
      .rdata (set_rdata[s])
    );
  end

  // Final read port k decodes copy k+1 of both sets.
  for (genvar k = 0; k < NUM_RD; k++) begin : g_decode
    assign rd_data[k*WIDTH +: WIDTH] =
      set_rdata[OWNER_A][(k+1)*WIDTH +: WIDTH] ^ set_rdata[OWNER_B][(k+1)*WIDTH +: WIDTH];
  end

endmodule

// File: rtl/xrf_checker.sv
module xrf_checker #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  parameter int NUM_RD = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wa_en,
  input logic [AW-1:0]           wa_addr,
  input logic [WIDTH-1:0]        wa_data,
  input logic                    wb_en,
  input logic [AW-1:0]           wb_addr,
  input logic [WIDTH-1:0]        wb_data,
  input logic [NUM_RD*AW-1:0]    rd_addr,
  input logic [NUM_RD*WIDTH-1:0] rd_data
);

  assert_no_same_addr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en && (wa_addr == wb_addr)));

  for (genvar k = 0; k < NUM_RD; k++) begin : g_port
    // R3: port A write visible on read port k after the edge
    assert_port_a_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wa_en) && (rd_addr[k*AW +: AW] == $past(wa_addr)) &&
       !($past(wb_en) && ($past(wb_addr) == $past(wa_addr))))
      |-> (rd_data[k*WIDTH +: WIDTH] == $past(wa_data)));

    // R4: port B write visible on read port k after the edge
    assert_port_b_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wb_en) && (rd_addr[k*AW +: AW] == $past(wb_addr)) &&
       !($past(wa_en) && ($past(wa_addr) == $past(wb_addr))))
      |-> (rd_data[k*WIDTH +: WIDTH] == $past(wb_data)));
  end

  // R8: without writes and with steady addresses the read data holds
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wa_en) && !$past(wb_en) && $stable(rd_addr))
    |-> $stable(rd_data));

endmodule

bind dual_write_xor_regfile xrf_checker #(
  .DEPTH  (DEPTH),
  .WIDTH  (WIDTH),
  .NUM_RD (NUM_RD)
) u_xrf_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .wa_en   (wa_en),
  .wa_addr (wa_addr),
  .wa_data (wa_data),
  .wb_en   (wb_en),
  .wb_addr (wb_addr),
  .wb_data (wb_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/test_dual_write_xor_regfile.sv
`timescale 1ns/1ps
module test_dual_write_xor_regfile;

  localparam int DEPTH  = 16;
  localparam int WIDTH  = 32;
  localparam int NUM_RD = 4;
  localparam int AW     = 4;

  typedef struct packed {
    logic             a_en;
    logic [AW-1:0]    a_addr;
    logic [WIDTH-1:0] a_data;
    logic             b_en;
    logic [AW-1:0]    b_addr;
    logic [WIDTH-1:0] b_data;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'd3,  32'hA5A5_0003, 1'b1, 4'd9,  32'h1234_5678},
    '{1'b1, 4'd9,  32'hDEAD_BEEF, 1'b0, 4'd3,  32'hFFFF_0000},
    '{1'b1, 4'd15, 32'hFFFF_FFFF, 1'b1, 4'd3,  32'h0BAD_F00D},
    '{1'b0, 4'd0,  32'h5555_5555, 1'b1, 4'd0,  32'h0000_0001},
    '{1'b1, 4'd0,  32'h0000_0002, 1'b1, 4'd15, 32'h0000_0007},
    '{1'b0, 4'd3,  32'h7777_7777, 1'b0, 4'd9,  32'h8888_8888},
    '{1'b1, 4'd14, 32'hCAFE_0000, 1'b1, 4'd1,  32'h0000_BABE},
    '{1'b1, 4'd1,  32'h2222_2222, 1'b1, 4'd14, 32'h1111_1111}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    wa_en = 1'b0;
  logic [AW-1:0]           wa_addr = '0;
  logic [WIDTH-1:0]        wa_data = '0;
  logic                    wb_en = 1'b0;
  logic [AW-1:0]           wb_addr = '0;
  logic [WIDTH-1:0]        wb_data = '0;
  logic [NUM_RD*AW-1:0]    rd_addr = '0;
  logic [NUM_RD*WIDTH-1:0] rd_data;

  logic [WIDTH-1:0] model [DEPTH];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_write_xor_regfile #(
    .DEPTH (DEPTH), .WIDTH (WIDTH), .NUM_RD (NUM_RD)
  ) i_dual_write_xor_regfile (
    .clk (clk), .rst_n (rst_n),
    .wa_en (wa_en), .wa_addr (wa_addr), .wa_data (wa_data),
    .wb_en (wb_en), .wb_addr (wb_addr), .wb_data (wb_data),
    .rd_addr (rd_addr), .rd_data (rd_data)
  );

  task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read every address through the four ports and compare with the model.
  task automatic sweep(input string req);
    for (int r = 0; r < DEPTH / NUM_RD; r++) begin
      for (int k = 0; k < NUM_RD; k++) rd_addr[k*AW +: AW] = AW'(r*NUM_RD + k);
      #0.5;
      for (int k = 0; k < NUM_RD; k++) chk(req, rd_data[k*WIDTH +: WIDTH], model[r*NUM_RD + k]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared state
    @(negedge clk);
    sweep("R1 reset");

    // Table walk: R3, R4, R5, R6, R8
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      wa_en = VECS[v].a_en; wa_addr = VECS[v].a_addr; wa_data = VECS[v].a_data;
      wb_en = VECS[v].b_en; wb_addr = VECS[v].b_addr; wb_data = VECS[v].b_data;
      @(posedge clk);
      #1;
      wa_en = 1'b0; wb_en = 1'b0;
      if (VECS[v].a_en) model[VECS[v].a_addr] = VECS[v].a_data;
      if (VECS[v].b_en) model[VECS[v].b_addr] = VECS[v].b_data;
      sweep("R3/R4/R5/R6/R8 table");
    end

    // R2 and R10: independent addresses, combinational change without a clock edge
    @(negedge clk);
    rd_addr = {4'd14, 4'd1, 4'd9, 4'd3};
    #0.3;
    chk("R10 port0", rd_data[0 +: WIDTH], model[3]);
    chk("R10 port1", rd_data[WIDTH +: WIDTH], model[9]);
    chk("R10 port2", rd_data[2*WIDTH +: WIDTH], model[1]);
    chk("R10 port3", rd_data[3*WIDTH +: WIDTH], model[14]);
    rd_addr = {4'd3, 4'd9, 4'd1, 4'd14};
    #0.3;
    chk("R2 port0", rd_data[0 +: WIDTH], model[14]);
    chk("R2 port3", rd_data[3*WIDTH +: WIDTH], model[3]);

    // R7 with R3: read of address under write by A
    @(negedge clk);
    wa_en = 1'b1; wa_addr = 4'd5; wa_data = 32'h0F0F_1234;
    rd_addr = {4'd5, 4'd5, 4'd5, 4'd5};
    #0.5;
    chk("R7 old before edge A", rd_data[0 +: WIDTH], model[5]);
    @(posedge clk);
    #1;
    wa_en = 1'b0;
    model[5] = 32'h0F0F_1234;
    chk("R3 new after edge", rd_data[3*WIDTH +: WIDTH], model[5]);

    // R7 with R4 and R6: B overwrites a location A just wrote
    @(negedge clk);
    wb_en = 1'b1; wb_addr = 4'd5; wb_data = 32'h9999_AAAA;
    #0.5;
    chk("R7 old before edge B", rd_data[WIDTH +: WIDTH], model[5]);
    @(posedge clk);
    #1;
    wb_en = 1'b0;
    model[5] = 32'h9999_AAAA;
    chk("R4/R6 new after edge", rd_data[2*WIDTH +: WIDTH], model[5]);

    // R8: disabled ports with live address and data
    @(negedge clk);
    wa_addr = 4'd5; wa_data = 32'h0; wb_addr = 4'd5; wb_data = 32'hFFFF_FFFF;
    @(posedge clk);
    #1;
    chk("R8 disabled writes", rd_data[0 +: WIDTH], model[5]);

    // R1: reset after writes clears everything
    do_reset();
    @(negedge clk);
    sweep("R1 re-reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule